// File: doc/BRIEF.md
# Compare-match interval timer

This block is a periodic interval timer with two independent channels behind a small 16-bit register bus. Each channel holds an up-counter, a compare register and a control/status register. A divided copy of the module clock advances the counter. When the counter has reached the compare value, the next counter clock does three things: it sets a sticky match flag, it returns the counter to zero, and it raises a level interrupt if that channel's interrupt enable is set.

Software picks one of four clock ratios for each channel. A single run register starts and stops both channels, one bit per channel. Software finds the remaining ticks by reading the counter and subtracting it from the compare value. It acknowledges an event by reading the status register and writing the value back with the flag bit at 0.

Top module: `cmt_timer`

## Requirements
- R1: After reset the run register reads 0x0000, each control/status register reads 0x0000, each counter reads 0x0000, each compare register reads 0xFFFF, and both interrupt lines are low.
- R2: Bit 0 of the run register (offset 0x0) runs channel 0 and bit 1 runs channel 1. A channel whose bit is 0 holds its counter, whatever the other channel does.
- R3: Control/status bits [1:0] select a counter-clock ratio of 8 << (2 × field), which gives 8, 32, 128 or 512. A running counter first advances that many cycles after its run bit is set, then once per ratio.
- R4: A counter clock that arrives while the counter equals its compare value returns the counter to 0 and sets the match flag (control/status bit 7). One full period is therefore (compare + 1) × ratio cycles.
- R5: The match flag stays set until software writes 0 to bit 7. Writing 1 to bit 7 leaves the flag unchanged.
- R6: If a match and a software clear of the flag fall in the same cycle, the flag ends up set.
- R7: Each channel's interrupt output equals its match flag AND its enable bit (control/status bit 6).
- R8: Software may write the counter and the compare register at any time, and the written value reads back in the very next cycle. A counter write takes priority over that cycle's count.
- R9: A channel's clock divider is cleared while the channel is stopped, so a restart always waits a full ratio before the first count.
- R10: Channel 0's control/status, counter and compare registers sit at 0x2, 0x4 and 0x6. Channel 1's sit at 0x8, 0xA and 0xC. Any other address reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | NUM_CH | Level interrupt for each channel |

## Verification
The bench builds the timer with its default parameters: two channels, a base ratio of 8 and a ratio step of 4. With these values even the slowest ratio of 512 fits inside a short directed run. Small compare values make the counter wrap within a few dozen cycles, so a flag clear can be written on exactly the cycle of a match. A stop-and-restart placed partway through a divider period shows whether the divider was cleared.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int WORD_W   = 16;
    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int CKS_W    = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic             flag;
        logic             ie;
        logic [CKS_W-1:0] cks;
    } csr_t;

    function automatic word_t csr_pack(csr_t c);
        word_t w;
        w              = '0;
        w[FLAG_BIT]    = c.flag;
        w[IE_BIT]      = c.ie;
        w[CKS_W-1:0]   = c.cks;
        return w;
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int BASE_LOG2 = 3,
    parameter int STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);

    localparam int PRE_W = BASE_LOG2 + STEP_LOG2 * ((1 << CKS_W) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    int unsigned      shift_c;
    logic [PRE_W-1:0] limit_c;

    always_comb begin
        shift_c = BASE_LOG2 + STEP_LOG2 * int'(cks);
        limit_c = ~({PRE_W{1'b1}} << shift_c);
        tick    = run && (st_q.pre >= limit_c);
        st_d    = st_q;
        if (!run || tick) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRE_CLEARED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.pre == '0);  // R9

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !tick);  // R9

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W     = WORD_W,
    parameter int BASE_LOG2 = 3,
    parameter int STEP_LOG2 = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  wr_csr,
    input  logic  wr_cnt,
    input  logic  wr_cmp,
    input  word_t wdata,
    output word_t csr_rd,
    output word_t cnt_rd,
    output word_t cmp_rd,
    output logic  irq
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        csr_t             csr;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        tick;
    logic        match_c;

    cmt_prescaler #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .cks   (st_q.csr.cks),
        .tick  (tick)
    );

    always_comb begin
        st_d    = st_q;
        match_c = tick && (st_q.cnt == st_q.cmp);

        if (match_c) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (wr_cnt) begin
            st_d.cnt = wdata[CNT_W-1:0];
        end
        if (wr_cmp) begin
            st_d.cmp = wdata[CNT_W-1:0];
        end

        if (wr_csr) begin
            st_d.csr.ie   = wdata[IE_BIT];
            st_d.csr.cks  = wdata[CKS_W-1:0];
            st_d.csr.flag = st_q.csr.flag & wdata[FLAG_BIT];
        end
        if (match_c) begin
            st_d.csr.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.cmp <= '1;
            st_q.csr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        csr_rd = csr_pack(st_q.csr);
        cnt_rd = '0;
        cmp_rd = '0;
        cnt_rd[CNT_W-1:0] = st_q.cnt;
        cmp_rd[CNT_W-1:0] = st_q.cmp;
        irq    = st_q.csr.flag & st_q.csr.ie;
    end

    AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && cnt_rd == cmp_rd) |=> (cnt_rd == '0));  // R4

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_rd == cmp_rd) |=> csr_rd[FLAG_BIT]);  // R6

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt_rd));  // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd[FLAG_BIT] && !(wr_csr && !wdata[FLAG_BIT])) |=> csr_rd[FLAG_BIT]);  // R5

    AST_FLAG_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_rd[FLAG_BIT] && !(tick && cnt_rd == cmp_rd)) |=> !csr_rd[FLAG_BIT]);  // R5

    AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt_rd[CNT_W-1:0] == $past(wdata[CNT_W-1:0]));  // R8

    AST_CMP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmp |=> cmp_rd[CNT_W-1:0] == $past(wdata[CNT_W-1:0]));  // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (csr_rd[FLAG_BIT] && csr_rd[IE_BIT]));  // R7

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 16,
    parameter int BASE_LOG2 = 3,
    parameter int STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int RUN_OFS   = 0;
    localparam int CH_BASE   = 2;
    localparam int CH_STRIDE = 6;
    localparam int OFS_CSR   = 0;
    localparam int OFS_CNT   = 2;
    localparam int OFS_CMP   = 4;

    typedef struct packed {
        logic [NUM_CH-1:0] run;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic              wr_any;
    logic [NUM_CH-1:0] wr_csr, wr_cnt, wr_cmp;
    word_t             csr_rd [NUM_CH];
    word_t             cnt_rd [NUM_CH];
    word_t             cmp_rd [NUM_CH];

    assign wr_any = bus_en && bus_we;

    always_comb begin
        st_d = st_q;
        if (wr_any && bus_addr == ADDR_W'(RUN_OFS)) begin
            st_d.run = bus_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = CH_BASE + CH_STRIDE * i;

        assign wr_csr[i] = wr_any && (bus_addr == ADDR_W'(BASE + OFS_CSR));
        assign wr_cnt[i] = wr_any && (bus_addr == ADDR_W'(BASE + OFS_CNT));
        assign wr_cmp[i] = wr_any && (bus_addr == ADDR_W'(BASE + OFS_CMP));

        cmt_channel #(
            .CNT_W     (CNT_W),
            .BASE_LOG2 (BASE_LOG2),
            .STEP_LOG2 (STEP_LOG2)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (st_q.run[i]),
            .wr_csr (wr_csr[i]),
            .wr_cnt (wr_cnt[i]),
            .wr_cmp (wr_cmp[i]),
            .wdata  (bus_wdata),
            .csr_rd (csr_rd[i]),
            .cnt_rd (cnt_rd[i]),
            .cmp_rd (cmp_rd[i]),
            .irq    (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en) begin
            if (bus_addr == ADDR_W'(RUN_OFS)) begin
                bus_rdata[NUM_CH-1:0] = st_q.run;
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + OFS_CSR)) bus_rdata = csr_rd[i];
                if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + OFS_CNT)) bus_rdata = cnt_rd[i];
                if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + OFS_CMP)) bus_rdata = cmp_rd[i];
            end
        end
    end

    AST_RUN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'(RUN_OFS)) |=> st_q.run == $past(bus_wdata[NUM_CH-1:0]));  // R2

    AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_csr, wr_cnt, wr_cmp}));  // R10

endmodule

// File: tb/cmt_timer_tb.sv
module cmt_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cmt_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        bus_en   = 1'b1;
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        v        = bus_rdata;
        bus_en   = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_en    = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en    = 1'b0;
        bus_we    = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk_reg("R1 run reg", 4'h0, 16'h0000);
        chk_reg("R1 csr0", 4'h2, 16'h0000);
        chk_reg("R1 cnt0", 4'h4, 16'h0000);
        chk_reg("R1 cmp0", 4'h6, 16'hFFFF);
        chk_reg("R1 csr1", 4'h8, 16'h0000);
        chk_reg("R1 cnt1", 4'hA, 16'h0000);
        chk_reg("R1 cmp1", 4'hC, 16'hFFFF);
        check("R1 irq", {14'b0, irq}, 16'h0000);
    endtask

    task automatic t_map;
        chk_reg("R10 unmapped 0xE", 4'hE, 16'h0000);
        wr(4'h2, 16'h0041);
        chk_reg("R10 csr0 at 0x2", 4'h2, 16'h0041);
        chk_reg("R10 csr1 untouched", 4'h8, 16'h0000);
        wr(4'h2, 16'h0000);
    endtask

    task automatic t_div8_match;
        wr(4'h6, 16'h0003);
        wr(4'h0, 16'h0001);
        wait_n(7);
        chk_reg("R3 no count before 8", 4'h4, 16'h0000);
        wait_n(1);
        chk_reg("R3 first count at 8", 4'h4, 16'h0001);
        wait_n(23);
        chk_reg("R4 cnt at compare", 4'h4, 16'h0003);
        chk_reg("R4 flag not yet", 4'h2, 16'h0000);
        wait_n(1);
        chk_reg("R4 wrap to zero", 4'h4, 16'h0000);
        chk_reg("R4 flag set", 4'h2, 16'h0080);
        check("R7 irq low with ie=0", {14'b0, irq}, 16'h0000);
        wr(4'h0, 16'h0000);
        wr(4'h2, 16'h00C0);
        chk_reg("R5 flag kept with write 1", 4'h2, 16'h00C0);
        check("R7 irq high", {14'b0, irq}, 16'h0001);
        wr(4'h2, 16'h0040);
        chk_reg("R5 flag cleared", 4'h2, 16'h0040);
        check("R7 irq low after clear", {14'b0, irq}, 16'h0000);
        wr(4'h2, 16'h00C0);
        chk_reg("R5 write 1 no set", 4'h2, 16'h0040);
        wr(4'h2, 16'h0000);
    endtask

    task automatic t_prescaler_reset;
        wr(4'h4, 16'h0000);
        wr(4'h6, 16'hFFFF);
        wr(4'h0, 16'h0001);
        wait_n(4);
        wr(4'h0, 16'h0000);
        wait_n(3);
        chk_reg("R2 stopped holds", 4'h4, 16'h0000);
        wr(4'h0, 16'h0001);
        wait_n(7);
        chk_reg("R9 full ratio after restart", 4'h4, 16'h0000);
        wait_n(1);
        chk_reg("R9 count after restart", 4'h4, 16'h0001);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_ch1_ratios;
        logic [15:0] c0, a, b;
        rd(4'h4, c0);
        wr(4'hA, 16'h0000);
        wr(4'h8, 16'h0001);
        wr(4'h0, 16'h0002);
        wait_n(31);
        chk_reg("R3 div32 early", 4'hA, 16'h0000);
        wait_n(1);
        chk_reg("R3 div32 count", 4'hA, 16'h0001);
        chk_reg("R2 ch0 idle while ch1 runs", 4'h4, c0);
        wr(4'h0, 16'h0000);
        wr(4'hA, 16'h0000);
        wr(4'h8, 16'h0003);
        wr(4'h0, 16'h0002);
        wait_n(511);
        chk_reg("R3 div512 early", 4'hA, 16'h0000);
        wait_n(1);
        chk_reg("R3 div512 count", 4'hA, 16'h0001);
        wr(4'hA, 16'h1234);
        chk_reg("R8 cnt write immediate", 4'hA, 16'h1234);
        wr(4'hC, 16'h0100);
        chk_reg("R8 cmp write", 4'hC, 16'h0100);
        wr(4'h0, 16'h0000);
        rd(4'hA, a);
        wait_n(40);
        rd(4'hA, b);
        check("R2 stopped ch1 holds", b, a);
        wr(4'h8, 16'h0000);
    endtask

    task automatic t_set_wins;
        wr(4'h2, 16'h0000);
        wr(4'h4, 16'h0000);
        wr(4'h6, 16'h0001);
        wr(4'h0, 16'h0001);
        wait_n(15);
        wr(4'h2, 16'h0000);
        chk_reg("R6 set beats clear", 4'h2, 16'h0080);
        chk_reg("R6 counter wrapped", 4'h4, 16'h0000);
        wr(4'h0, 16'h0000);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_map();
        t_div8_match();
        t_prescaler_reset();
        t_ch1_ratios();
        t_set_wins();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule